// File: doc/BRIEF.md
# ADC Command and Readback Controller

This block sits between a host register bus and a small register file of 16-bit converter registers. The host sends packed command words to a command port. Each word asks for a read, a write or a no-op on one converter register. Commands take effect in the cycle they arrive, so the command queue is always empty. A read result does not come back for its own command. Each accepted command pushes the result held from the previous command into a readback FIFO and then holds its own result. Writes and no-ops hold zero. The host pops results through a readback port.

The block also holds a configuration register, an interrupt status register with write-one-to-clear bits, an interrupt mask, a read-only status register and a control register. The control register has a channel-reset bit. While that bit is set, commands are dropped. A single level interrupt output reflects any unmasked pending status bit.

Host accesses use a single-cycle request with a write strobe and a 5-bit byte offset. Read data is combinational in the request cycle. A pop takes effect at the closing clock edge of that cycle.

Top module: `adc_cmd_ctrl`

## Requirements
- R1: After reset, config reads 0x0000_1114 (gap field 0x14 in bits 4:0, rate code 1 in bits 9:8, bit 12 set). Interrupt status reads 0x200, mask reads 0x3FF, status reads 0x500, control reads 0x10 and the interrupt output is 0.
- R2: Word offsets are: 0x00 config (read/write), 0x04 interrupt status (read/write), 0x08 mask (read/write), 0x0C status (read only), 0x10 command (write only), 0x14 readback (read only) and 0x18 control (read/write). An access to an unlisted offset, in a disallowed direction, or with address bits 1:0 not zero has no effect and reads as zero.
- R3: A command word carries the opcode in bits 29:26, the register address in bits 25:16 and the write data in bits 15:0. Opcode 1 (read) pushes the held previous result into the FIFO and then holds the addressed register's value.
- R4: Opcode 2 (write) stores its data into the addressed register, pushes the held result and holds zero. Opcode 0 (no-op) is accepted with any address, pushes the held result and holds zero.
- R5: A read or write with address 128 or more, and any opcode other than 0, 1 or 2, is ignored. It pushes nothing, leaves the held result unchanged and alters no register.
- R6: The FIFO holds 15 entries. A push into a full FIFO is lost, but the held result is still replaced by the new command's result.
- R7: A read of the readback port returns the oldest entry and removes it. A read of an empty FIFO returns 0 and the count stays 0.
- R8: Status holds the FIFO count in bits 15:12, FIFO full in bit 9 and FIFO empty in bit 8. Bit 10 (command queue empty) always reads 1. All other bits read 0.
- R9: On every valid host write and every pop, interrupt status bit 9 is set. Bit 8 is also set if the resulting FIFO count exceeds config bits 19:16. Both bits stay set until cleared by writing 1 to them; the same update may set them again.
- R10: The mask keeps only bits 9:0. The interrupt output is high exactly when some status bit is set whose mask bit is 0. It takes its new value in the cycle after the access.
- R11: Control writes are ANDed with 0x00FF_FEFF. While control bit 4 is set, command writes are dropped without changing the FIFO, the held result or the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_req | input | 1 | Host access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the request cycle |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach is a FIFO that is full while the held result keeps changing. The full FIFO must drop pushes, yet the next result after the drain must come from the last command, not from a lost one. The stimulus issues twenty read commands to distinct registers, each loaded beforehand with a distinct value by a sweep over all 128 addresses. It then drains the 15 entries and sends one more no-op. The pop after that no-op must show the value of the final read. A second hard case is the sticky threshold bit. The stimulus steps the fill count across the threshold one push at a time, then drains, then clears the bit. This shows the bit is set exactly at the crossing and survives the drain.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;

  typedef enum logic [2:0] {
    SEL_CFG   = 3'd0,
    SEL_ISTS  = 3'd1,
    SEL_IMASK = 3'd2,
    SEL_STAT  = 3'd3,
    SEL_CMD   = 3'd4,
    SEL_RDBK  = 3'd5,
    SEL_CTRL  = 3'd6,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  localparam logic [3:0] OP_NOP   = 4'd0;
  localparam logic [3:0] OP_READ  = 4'd1;
  localparam logic [3:0] OP_WRITE = 4'd2;

  localparam int OP_LSB    = 26;
  localparam int RADDR_LSB = 16;
  localparam int RADDR_W   = 10;
  localparam int CDATA_W   = 16;

  localparam logic [31:0] CFG_RESET  = 32'h0000_1114;
  localparam logic [31:0] CTRL_RESET = 32'h0000_0010;
  localparam logic [31:0] CTRL_KEEP  = 32'h00FF_FEFF;
  localparam int          CHRST_BIT  = 4;
  localparam int          THR_LSB    = 16;
  localparam int          THR_W      = 4;

  localparam int ISTS_W     = 10;
  localparam int ISTS_BELOW = 9;
  localparam int ISTS_ABOVE = 8;

endpackage

// File: rtl/adc_regfile.sv
module adc_regfile #(
  parameter int NUM = 128,
  parameter int DW  = 16,
  localparam int IW = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_entry
    logic hit;
    assign hit = we && (waddr == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[g] <= '0;
      else if (hit) mem_q[g] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

  // R4: a write is visible on the read port at the same address next cycle
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we && (raddr == waddr) |=> $stable(raddr) -> (rdata == $past(wdata)));

endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
  parameter int DEPTH = 15,
  parameter int DW    = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_val,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] slot_q [DEPTH];
  logic [DW-1:0] slot_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] held_q, held_d;

  always_comb begin
    slot_d = slot_q;
    cnt_d  = cnt_q;
    held_d = held_q;
    if (push) begin
      if (cnt_q < CW'(DEPTH)) begin
        slot_d[cnt_q] = held_q;
        cnt_d         = cnt_q + CW'(1);
      end
      held_d = push_val;
    end else if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) slot_d[i] = slot_q[i+1];
      slot_d[DEPTH-1] = '0;
      if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      cnt_q  <= '0;
      held_q <= '0;
    end else begin
      slot_q <= slot_d;
      cnt_q  <= cnt_d;
      held_q <= held_d;
    end
  end

  assign head      = slot_q[0];
  assign count     = cnt_q;
  assign count_nxt = cnt_d;
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push && (cnt_q == CW'(DEPTH)) |=> (cnt_q == CW'(DEPTH)) && (held_q == $past(push_val)));

  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && (cnt_q == '0) |=> (cnt_q == '0));

  p_empty_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> (slot_q[0] == '0));

endmodule

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl
  import adc_cmd_pkg::*;
#(
  parameter int SW = ISTS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          update,
  input  logic          above_thr,
  input  logic          sts_clr_we,
  input  logic          mask_we,
  input  logic [SW-1:0] wbits,
  output logic [SW-1:0] sts,
  output logic [SW-1:0] mask,
  output logic          irq
);

  logic [SW-1:0] sts_q, sts_d, mask_q, mask_d;
  logic          irq_q, irq_d;

  always_comb begin
    sts_d  = sts_q;
    mask_d = mask_q;
    if (sts_clr_we) sts_d = sts_d & ~wbits;
    if (update) begin
      sts_d[ISTS_BELOW] = 1'b1;
      if (above_thr) sts_d[ISTS_ABOVE] = 1'b1;
    end
    if (mask_we) mask_d = wbits;
    irq_d = |(sts_d & ~mask_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= SW'(1) << ISTS_BELOW;
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      sts_q  <= sts_d;
      mask_q <= mask_d;
      irq_q  <= irq_d;
    end
  end

  assign sts  = sts_q;
  assign mask = mask_q;
  assign irq  = irq_q;

  p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == |(sts_q & ~mask_q));

  p_update_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> sts_q[ISTS_BELOW]);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[ISTS_ABOVE] && !sts_clr_we |=> sts_q[ISTS_ABOVE]);

endmodule

// File: rtl/adc_cmd_ctrl.sv
module adc_cmd_ctrl
  import adc_cmd_pkg::*;
#(
  parameter int NUM_REGS  = 128,
  parameter int RES_DEPTH = 15,
  parameter int RF_DW     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o
);

  localparam int IW = $clog2(NUM_REGS);
  localparam int CW = $clog2(RES_DEPTH + 1);

  reg_sel_e sel;
  logic     aligned, rd_ok, wr_ok;

  assign sel     = reg_sel_e'(bus_addr[4:2]);
  assign aligned = (bus_addr[1:0] == 2'b00);

  always_comb begin
    rd_ok = 1'b0;
    wr_ok = 1'b0;
    if (bus_req && aligned) begin
      unique case (sel)
        SEL_CFG, SEL_ISTS, SEL_IMASK, SEL_CTRL: begin
          rd_ok = !bus_we;
          wr_ok = bus_we;
        end
        SEL_STAT, SEL_RDBK: rd_ok = !bus_we;
        SEL_CMD:            wr_ok = bus_we;
        default: ;
      endcase
    end
  end

  // Command parsing
  logic [3:0]         cmd_op;
  logic [RADDR_W-1:0] cmd_addr;
  logic [CDATA_W-1:0] cmd_data;
  logic               cmd_fire, in_range, cmd_accept, rf_we, pop;
  logic [RF_DW-1:0]   rf_rdata, new_held;
  logic [31:0]        cfg_q, cfg_d, ctrl_q, ctrl_d;

  assign cmd_op   = bus_wdata[OP_LSB +: 4];
  assign cmd_addr = bus_wdata[RADDR_LSB +: RADDR_W];
  assign cmd_data = bus_wdata[0 +: CDATA_W];

  assign cmd_fire   = wr_ok && (sel == SEL_CMD) && !ctrl_q[CHRST_BIT];
  assign in_range   = ({1'b0, cmd_addr} < (RADDR_W + 1)'(NUM_REGS));
  assign cmd_accept = cmd_fire &&
                      ((cmd_op == OP_NOP) ||
                       (((cmd_op == OP_READ) || (cmd_op == OP_WRITE)) && in_range));
  assign rf_we      = cmd_fire && (cmd_op == OP_WRITE) && in_range;
  assign new_held   = (cmd_op == OP_READ) ? rf_rdata : '0;
  assign pop        = rd_ok && (sel == SEL_RDBK);

  adc_regfile #(.NUM(NUM_REGS), .DW(RF_DW)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (cmd_addr[IW-1:0]),
    .wdata (cmd_data[RF_DW-1:0]),
    .raddr (cmd_addr[IW-1:0]),
    .rdata (rf_rdata)
  );

  logic [RF_DW-1:0] fifo_head;
  logic [CW-1:0]    fifo_cnt, fifo_cnt_nxt;
  logic             fifo_full, fifo_empty;

  adc_result_fifo #(.DEPTH(RES_DEPTH), .DW(RF_DW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (cmd_accept),
    .push_val  (new_held),
    .pop       (pop),
    .head      (fifo_head),
    .count     (fifo_cnt),
    .count_nxt (fifo_cnt_nxt),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  // Configuration and control registers
  always_comb begin
    cfg_d  = cfg_q;
    ctrl_d = ctrl_q;
    if (wr_ok && (sel == SEL_CFG))  cfg_d  = bus_wdata;
    if (wr_ok && (sel == SEL_CTRL)) ctrl_d = bus_wdata & CTRL_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      ctrl_q <= CTRL_RESET;
    end else begin
      cfg_q  <= cfg_d;
      ctrl_q <= ctrl_d;
    end
  end

  // Interrupts
  logic              above_thr;
  logic [ISTS_W-1:0] sts, mask;

  assign above_thr = (32'(fifo_cnt_nxt) > 32'(cfg_d[THR_LSB +: THR_W]));

  adc_irq_ctrl #(.SW(ISTS_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .update     (wr_ok || pop),
    .above_thr  (above_thr),
    .sts_clr_we (wr_ok && (sel == SEL_ISTS)),
    .mask_we    (wr_ok && (sel == SEL_IMASK)),
    .wbits      (bus_wdata[ISTS_W-1:0]),
    .sts        (sts),
    .mask       (mask),
    .irq        (irq_o)
  );

  // Read mux
  logic [31:0] stat_word;
  assign stat_word = {16'b0, 4'(fifo_cnt), 1'b0, 1'b1, fifo_full, fifo_empty, 8'b0};

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      unique case (sel)
        SEL_CFG:   bus_rdata = cfg_q;
        SEL_ISTS:  bus_rdata = 32'(sts);
        SEL_IMASK: bus_rdata = 32'(mask);
        SEL_STAT:  bus_rdata = stat_word;
        SEL_RDBK:  bus_rdata = 32'(fifo_head);
        SEL_CTRL:  bus_rdata = ctrl_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  p_chrst_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && aligned && (sel == SEL_CMD) && ctrl_q[CHRST_BIT]
      |=> $stable(fifo_cnt) && $stable(fifo_head));

  p_ctrl_clear_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[8] && (ctrl_q[31:24] == 8'h00));

  p_bad_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !rd_ok |-> (bus_rdata == 32'h0));

endmodule

// File: tb/adc_cmd_ctrl_test.sv
`timescale 1ns/1ps
module adc_cmd_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o;

  always #2.5 clk = ~clk;

  adc_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Reference model state
  int m_fifo [15];
  int m_cnt  = 0;
  int m_held = 0;
  int m_rf   [128];
  bit m_chrst = 1;

  function automatic int fval(int i);
    return (i * 16'h0ACE + 16'h1357) & 16'hFFFF;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic access(input logic we, input logic [4:0] a, input logic [31:0] d,
                        output logic [31:0] r);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    #1 r = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] r;
    access(1'b1, a, d, r);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] r);
    access(1'b0, a, 32'h0, r);
  endtask

  task automatic cmd(input int op, input int a, input int d);
    wr(5'h10, {2'b00, 4'(op), 10'(a), 16'(d)});
    if (!m_chrst && (op == 0 || ((op == 1 || op == 2) && a < 128))) begin
      if (m_cnt < 15) begin m_fifo[m_cnt] = m_held; m_cnt++; end
      m_held = (op == 1) ? m_rf[a] : 0;
      if (op == 2) m_rf[a] = d & 16'hFFFF;
    end
  endtask

  task automatic pop_check(input string tag);
    logic [31:0] r;
    int exp;
    rd(5'h14, r);
    exp = (m_cnt > 0) ? m_fifo[0] : 0;
    if (m_cnt > 0) begin
      for (int i = 0; i < 14; i++) m_fifo[i] = m_fifo[i+1];
      m_cnt--;
    end
    check(tag, r, 32'(exp));
  endtask

  task automatic stat_check(input string tag);
    logic [31:0] r;
    int exp;
    rd(5'h0C, r);
    exp = (m_cnt << 12) | 32'h400 | ((m_cnt == 15) ? 32'h200 : 0) | ((m_cnt == 0) ? 32'h100 : 0);
    check(tag, r, 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 128; i++) m_rf[i] = 0;
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'h00, r); check("R1 config", r, 32'h0000_1114);
    rd(5'h04, r); check("R1 int status", r, 32'h200);
    rd(5'h08, r); check("R1 mask", r, 32'h3FF);
    rd(5'h0C, r); check("R1 status", r, 32'h500);
    rd(5'h18, r); check("R1 control", r, 32'h10);
    check("R1 irq", 32'(irq_o), 32'h0);

    // R2 access rules
    rd(5'h10, r); check("R2 read command port", r, 32'h0);
    rd(5'h1C, r); check("R2 read unmapped", r, 32'h0);
    rd(5'h01, r); check("R2 unaligned read", r, 32'h0);
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h02, 32'h0);
    rd(5'h00, r); check("R2 unaligned write ignored", r, 32'h0000_1114);
    stat_check("R2 status after illegal writes");

    // R11 channel reset gate and control write mask
    cmd(0, 0, 0);
    cmd(2, 3, 16'hBEEF);
    stat_check("R11 command dropped in reset");
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, r); check("R11 control mask", r, 32'h00FF_FEFF);
    wr(5'h18, 32'h0); m_chrst = 0;
    rd(5'h18, r); check("R11 control cleared", r, 32'h0);

    // R4 write sweep over every register, then R3 read sweep
    for (int i = 0; i < 128; i++) begin
      cmd(2, i, fval(i));
      pop_check("R4 write pushes zero result");
    end
    for (int i = 0; i < 128; i++) begin
      cmd(1, i, 0);
      pop_check("R3 delayed read result");
    end
    cmd(0, 999, 0);
    pop_check("R3 last read via no-op");
    stat_check("R8 empty after sweep");

    // R5 ignored commands
    cmd(1, 5, 0);
    cmd(1, 200, 0);
    cmd(3, 2, 0);
    cmd(2, 130, 16'hDEAD);
    stat_check("R5 ignored commands push nothing");
    cmd(1, 2, 0);
    cmd(0, 0, 0);
    pop_check("R5 held kept across ignored");
    pop_check("R5 held kept across ignored");
    pop_check("R5 out-of-range write did not alias");
    stat_check("R8 empty again");

    // R6 full FIFO, held result still replaced
    for (int k = 0; k < 20; k++) cmd(1, k + 40, 0);
    stat_check("R6 R8 full status");
    for (int k = 0; k < 15; k++) pop_check("R6 drain full FIFO");
    cmd(0, 0, 0);
    pop_check("R6 held replaced while full");

    // R7 empty pop
    pop_check("R7 empty pop returns zero");
    stat_check("R7 count stays zero");

    // R9 / R10 interrupts
    wr(5'h00, 32'h0002_1114);
    rd(5'h00, r); check("R9 config readback", r, 32'h0002_1114);
    wr(5'h08, 32'h0);
    check("R10 irq after unmask", 32'(irq_o), 32'h1);
    wr(5'h04, 32'h3FF);
    rd(5'h04, r); check("R9 below bit re-set on clear", r, 32'h200);
    cmd(0, 0, 0); cmd(0, 0, 0);
    rd(5'h04, r); check("R9 at threshold no above", r, 32'h200);
    cmd(0, 0, 0);
    rd(5'h04, r); check("R9 above threshold set", r, 32'h300);
    for (int k = 0; k < 3; k++) pop_check("R9 drain");
    rd(5'h04, r); check("R9 above bit sticky", r, 32'h300);
    wr(5'h04, 32'h100);
    rd(5'h04, r); check("R9 W1C above bit", r, 32'h200);
    wr(5'h08, 32'h200);
    check("R10 irq masked", 32'(irq_o), 32'h0);
    wr(5'h08, 32'h100);
    check("R10 irq unmasked below bit", 32'(irq_o), 32'h1);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, r); check("R10 mask width", r, 32'h3FF);
    check("R10 irq all masked", 32'(irq_o), 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule